// File: doc/BRIEF.md
# CAN Receive Mailbox Bank with Acceptance Filtering

This block holds a small set of receive mailboxes for a CAN controller. A decoded frame arrives from the bit-level engine as one stream beat: identifier, extended flag, remote flag, data length code and up to eight payload bytes. The block compares the frame against every mailbox that is switched on and set for receive. The lowest-numbered mailbox that accepts the frame stores it and flags it as pending. If no mailbox accepts the frame, the frame is dropped.

Each mailbox has these parts:
- a pair of 16-bit identifier words;
- an optional per-bit acceptance mask;
- a 4-bit length code;
- four 16-bit data words, with the bytes packed pairwise in reverse order.

The host configures the filters, reads stored frames and clears the pending and lost flags through a plain register port. Reads are combinational. One output gives a summary receive interrupt.

Frame input follows valid/ready rules. A frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. While `frm_valid` is high, the source holds the frame unchanged until that edge. `frm_ready` drops in every cycle that carries a host write. Host writes therefore always win, and a frame and a host write never update the same storage in one cycle. One cycle after each accepted frame, a result pulse reports whether a mailbox took it and which one.

Top module: `can_mb_bank`

## Requirements
- R1: After reset every register reads zero, `frm_ready` is high, `done_valid` is low and `rx_irq` is low.
- R2: Register addresses:
  - With address bit 7 clear, the global registers are: 0 enable, 1 direction (1 = receive), 2 pending, 3 lost.
  - With bit 7 set, bits 6:4 select the mailbox and bits 3:0 select a slot: 0 identifier low, 1 identifier high, 2 mask low, 3 mask high (13 bits), 4 length code (4 bits), 5 to 8 data words 0 to 3.
  - Reads return the value in the same cycle.
- R3: Identifier high word layout:
  - Bit 15 is mask-enable, bit 14 is remote and bit 13 is extended.
  - A standard 11-bit identifier sits in bits 12:2.
  - An extended 29-bit identifier puts its upper 13 bits in bits 12:0 of the high word and its lower 16 bits in the low word.
- R4: A mailbox accepts a frame only when the extended flag equals high-word bit 13. With mask-enable at 0, every identifier bit must match. With mask-enable at 1, a mask bit of 1 makes that identifier bit a don't-care. The remote flag is never compared.
- R5: Only mailboxes with both their enable bit and their direction bit at 1 take part in matching.
- R6: When several mailboxes accept a frame, the lowest-numbered one stores it.
- R7: On store:
  - The identifier is written from the frame. A standard frame leaves the low word unchanged and writes zeros to high-word bits 1:0.
  - Bit 14 takes the frame's remote flag, bit 15 keeps its value, and the length code is stored as received.
- R8: Byte j of the payload is `frm_data[8j+7:8j]`. Data word k holds byte 7-2k in bits 7:0 and byte 6-2k in bits 15:8.
- R9: Bytes at index min(length code, 8) or above are stored as zero.
- R10: A store sets the mailbox's pending bit. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. `rx_irq` is the OR of all pending bits.
- R11: A store into a mailbox whose pending bit is already set also sets its lost bit. Lost bits clear only when 1 is written to them.
- R12: `frm_ready` is low in any cycle where `reg_we` is high. `done_valid` pulses exactly one cycle after each accepted frame. In that cycle, `done_hit` and `done_mb` report the result. A frame no mailbox accepts changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame beat valid |
| frm_ready | output | 1 | Frame beat may be taken |
| frm_ide | input | 1 | Frame uses extended identifier |
| frm_rtr | input | 1 | Remote frame |
| frm_id | input | 29 | Identifier (standard uses bits 10:0) |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload, byte j at bits 8j+7:8j |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data (combinational) |
| done_valid | output | 1 | Result pulse, one cycle after acceptance |
| done_hit | output | 1 | A mailbox stored the frame |
| done_mb | output | 3 | Index of the storing mailbox |
| rx_irq | output | 1 | Any mailbox pending |

## Verification
The bench sends a sequence of frames, and each one separates a different decision:
- A standard frame accepted by both an exact filter and an accept-all filter confirms that the lower index wins.
- A neighbouring standard identifier fails the exact filter and falls through to the accept-all filter, which shows exact comparison working.
- Two extended identifiers differ in one bit: the first lies under the don't-care mask bits, the second just outside them. This separates masked from compared bits.
- The second of these also skips past mailboxes that are disabled or set for transmit.

A short payload and a zero-length payload exercise byte zeroing. A repeated frame into a still-pending mailbox raises the lost flag. Finally, a standard frame offered only to an extended filter must be dropped with no register change.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  localparam int WORD_W = 16;
  localparam int ID_W   = 29;
  localparam int SLOT_W = 4;
  localparam int BYTES  = 8;

  // Control bits of the identifier high word
  localparam int B_AME = 15;
  localparam int B_RTR = 14;
  localparam int B_IDE = 13;

  typedef enum logic [SLOT_W-1:0] {
    SL_ID_LO  = 4'd0,
    SL_ID_HI  = 4'd1,
    SL_MSK_LO = 4'd2,
    SL_MSK_HI = 4'd3,
    SL_DLC    = 4'd4,
    SL_D0     = 4'd5,
    SL_D1     = 4'd6,
    SL_D2     = 4'd7,
    SL_D3     = 4'd8
  } slot_e;

  typedef enum logic [SLOT_W-1:0] {
    G_ENABLE = 4'd0,
    G_DIR    = 4'd1,
    G_PEND   = 4'd2,
    G_LOST   = 4'd3
  } greg_e;
endpackage

// File: rtl/can_mb_match.sv
module can_mb_match
  import can_mb_pkg::*;
(
  input  logic [WORD_W-1:0] id_lo,
  input  logic [WORD_W-1:0] id_hi,
  input  logic [WORD_W-1:0] msk_lo,
  input  logic [12:0]       msk_hi,
  input  logic              frm_ide,
  input  logic [ID_W-1:0]   frm_id,
  output logic              hit
);
  logic [ID_W-1:0] ref_id;
  logic [ID_W-1:0] care;

  always_comb begin
    if (id_hi[B_IDE]) begin
      ref_id = {id_hi[12:0], id_lo};
      care   = id_hi[B_AME] ? ~{msk_hi, msk_lo} : '1;
    end else begin
      ref_id = {18'd0, id_hi[12:2]};
      care   = id_hi[B_AME] ? {18'd0, ~msk_hi[12:2]} : {18'd0, 11'h7FF};
    end
    hit = (id_hi[B_IDE] == frm_ide) && (((ref_id ^ frm_id) & care) == '0);
  end
endmodule

// File: rtl/can_mb_prio.sv
module can_mb_prio #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/can_mb_pack.sv
module can_mb_pack
  import can_mb_pkg::*;
(
  input  logic [8*BYTES-1:0]   data,
  input  logic [3:0]           dlc,
  output logic [3:0][WORD_W-1:0] words
);
  logic [3:0] len;
  assign len = (dlc > 4'd8) ? 4'd8 : dlc;

  for (genvar k = 0; k < 4; k++) begin : g_word
    localparam int LO_B = 7 - 2 * k;
    localparam int HI_B = 6 - 2 * k;
    assign words[k][7:0]  = (4'(LO_B) < len) ? data[8*LO_B +: 8] : 8'h00;
    assign words[k][15:8] = (4'(HI_B) < len) ? data[8*HI_B +: 8] : 8'h00;
  end
endmodule

// File: rtl/can_mb_bank.sv
module can_mb_bank
  import can_mb_pkg::*;
#(
  parameter int NUM_MB = 8,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int AW    = 1 + IDX_W + SLOT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic                frm_ide,
  input  logic                frm_rtr,
  input  logic [ID_W-1:0]     frm_id,
  input  logic [3:0]          frm_dlc,
  input  logic [8*BYTES-1:0]  frm_data,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                done_valid,
  output logic                done_hit,
  output logic [IDX_W-1:0]    done_mb,
  output logic                rx_irq
);
  logic [WORD_W-1:0] id_lo  [NUM_MB];
  logic [WORD_W-1:0] id_hi  [NUM_MB];
  logic [WORD_W-1:0] msk_lo [NUM_MB];
  logic [12:0]       msk_hi [NUM_MB];
  logic [3:0]        dlc_q  [NUM_MB];
  logic [WORD_W-1:0] dat    [NUM_MB][4];
  logic [NUM_MB-1:0] mb_en, mb_dir, pend, lost;

  logic [NUM_MB-1:0] hit, req;
  logic              win_any;
  logic [IDX_W-1:0]  win;
  logic [3:0][WORD_W-1:0] packed_w;
  logic              acc;

  logic              a_mb;
  logic [IDX_W-1:0]  a_idx;
  logic [SLOT_W-1:0] a_slot;
  logic              a_ok;

  assign a_mb   = reg_addr[AW-1];
  assign a_idx  = reg_addr[SLOT_W +: IDX_W];
  assign a_slot = reg_addr[SLOT_W-1:0];
  assign a_ok   = int'(a_idx) < NUM_MB;

  assign frm_ready = ~reg_we;
  assign acc       = frm_valid & frm_ready;
  assign rx_irq    = |pend;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    can_mb_match u_match (
      .id_lo  (id_lo[i]),
      .id_hi  (id_hi[i]),
      .msk_lo (msk_lo[i]),
      .msk_hi (msk_hi[i]),
      .frm_ide(frm_ide),
      .frm_id (frm_id),
      .hit    (hit[i])
    );
  end

  assign req = hit & mb_en & mb_dir;

  can_mb_prio #(.N(NUM_MB)) u_prio (.req(req), .any(win_any), .idx(win));

  can_mb_pack u_pack (.data(frm_data), .dlc(frm_dlc), .words(packed_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MB; i++) begin
        id_lo[i]  <= '0;
        id_hi[i]  <= '0;
        msk_lo[i] <= '0;
        msk_hi[i] <= '0;
        dlc_q[i]  <= '0;
        for (int k = 0; k < 4; k++) dat[i][k] <= '0;
      end
      mb_en      <= '0;
      mb_dir     <= '0;
      pend       <= '0;
      lost       <= '0;
      done_valid <= 1'b0;
      done_hit   <= 1'b0;
      done_mb    <= '0;
    end else begin
      if (reg_we) begin
        if (a_mb) begin
          if (a_ok) begin
            case (slot_e'(a_slot))
              SL_ID_LO:  id_lo[a_idx]  <= reg_wdata;
              SL_ID_HI:  id_hi[a_idx]  <= reg_wdata;
              SL_MSK_LO: msk_lo[a_idx] <= reg_wdata;
              SL_MSK_HI: msk_hi[a_idx] <= reg_wdata[12:0];
              SL_DLC:    dlc_q[a_idx]  <= reg_wdata[3:0];
              SL_D0:     dat[a_idx][0] <= reg_wdata;
              SL_D1:     dat[a_idx][1] <= reg_wdata;
              SL_D2:     dat[a_idx][2] <= reg_wdata;
              SL_D3:     dat[a_idx][3] <= reg_wdata;
              default: ;
            endcase
          end
        end else begin
          case (greg_e'(a_slot))
            G_ENABLE: mb_en  <= reg_wdata[NUM_MB-1:0];
            G_DIR:    mb_dir <= reg_wdata[NUM_MB-1:0];
            G_PEND:   pend   <= pend & ~reg_wdata[NUM_MB-1:0];
            G_LOST:   lost   <= lost & ~reg_wdata[NUM_MB-1:0];
            default: ;
          endcase
        end
      end else if (acc && win_any) begin
        id_hi[win] <= {id_hi[win][B_AME], frm_rtr, frm_ide,
                       frm_ide ? frm_id[28:16] : {frm_id[10:0], 2'b00}};
        if (frm_ide) id_lo[win] <= frm_id[15:0];
        dlc_q[win] <= frm_dlc;
        for (int k = 0; k < 4; k++) dat[win][k] <= packed_w[k];
        pend[win] <= 1'b1;
        if (pend[win]) lost[win] <= 1'b1;
      end
      done_valid <= acc;
      done_hit   <= acc & win_any;
      done_mb    <= win;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (a_mb) begin
      if (a_ok) begin
        case (slot_e'(a_slot))
          SL_ID_LO:  reg_rdata = id_lo[a_idx];
          SL_ID_HI:  reg_rdata = id_hi[a_idx];
          SL_MSK_LO: reg_rdata = msk_lo[a_idx];
          SL_MSK_HI: reg_rdata = {3'b000, msk_hi[a_idx]};
          SL_DLC:    reg_rdata = {12'h000, dlc_q[a_idx]};
          SL_D0:     reg_rdata = dat[a_idx][0];
          SL_D1:     reg_rdata = dat[a_idx][1];
          SL_D2:     reg_rdata = dat[a_idx][2];
          SL_D3:     reg_rdata = dat[a_idx][3];
          default:   reg_rdata = '0;
        endcase
      end
    end else begin
      case (greg_e'(a_slot))
        G_ENABLE: reg_rdata[NUM_MB-1:0] = mb_en;
        G_DIR:    reg_rdata[NUM_MB-1:0] = mb_dir;
        G_PEND:   reg_rdata[NUM_MB-1:0] = pend;
        G_LOST:   reg_rdata[NUM_MB-1:0] = lost;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/can_mb_chk.sv
module can_mb_chk #(
  parameter int NUM_MB = 8,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             reg_we,
  input logic             done_valid,
  input logic             done_hit,
  input logic [IDX_W-1:0] done_mb,
  input logic             rx_irq
);
  // R12: an accepted beat produces a result pulse next cycle
  a_r12_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> done_valid);

  // R12: no result pulse without an accepted beat
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_ready) |=> !done_valid);

  // R12: a beat offered during a host write is not taken
  a_r12_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && reg_we) |=> !done_valid);

  // R12: hit is only reported inside a result pulse
  a_r12_hit_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |-> done_valid);

  // R10: a store leaves the interrupt raised
  a_r10_irq_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |-> rx_irq);

  // R10: the interrupt rises only because of a store
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> done_hit);
endmodule

bind can_mb_bank can_mb_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .reg_we    (reg_we),
  .done_valid(done_valid),
  .done_hit  (done_hit),
  .done_mb   (done_mb),
  .rx_irq    (rx_irq)
);

// File: tb/can_mb_bank_bench.sv
module can_mb_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic        frm_ready;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        done_valid, done_hit, rx_irq;
  logic [2:0]  done_mb;

  int n_cmp = 0, n_bad = 0;
  logic [3:0] exp_q[$];   // {hit, mailbox}
  bit done_flag = 0;

  always #10 clk = ~clk;

  can_mb_bank u_can_mb_bank (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done_valid(done_valid), .done_hit(done_hit),
    .done_mb(done_mb), .rx_irq(rx_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mba(int i, int s);
    return 8'(128 + i * 16 + s);
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    #1 chk("R12 ready low during write", 32'(frm_ready), 32'd0);
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  function automatic logic [63:0] pay();
    logic [63:0] p;
    for (int j = 0; j < 8; j++) p[8*j +: 8] = 8'(8'h11 * (j + 1));
    return p;
  endfunction

  task automatic send(logic ide, logic rtr, logic [28:0] id, logic [3:0] dlc,
                      logic hit, int mb);
    exp_q.push_back({hit, 3'(mb)});
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id;
    frm_dlc = dlc; frm_data = pay();
    @(posedge clk);
    #1 frm_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected result pulse", 32'd1, 32'd0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk("R12 result hit", 32'(done_hit), 32'(e[3]));
        if (e[3]) chk("R6 result mailbox", 32'(done_mb), 32'(e[2:0]));
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd("R1 enable", 8'h00, 16'h0);
    rd("R1 pending", 8'h02, 16'h0);
    rd("R1 id high mb0", mba(0, 1), 16'h0);
    chk("R1 ready", 32'(frm_ready), 32'd1);
    chk("R1 irq", 32'(rx_irq), 32'd0);
    chk("R1 done", 32'(done_valid), 32'd0);

    // R2/R3 configuration
    wr(mba(0, 1), 16'h048C);                       // std 0x123 exact
    wr(mba(1, 1), 16'hBABC); wr(mba(1, 0), 16'hDE00); wr(mba(1, 2), 16'h00FF);
    wr(mba(2, 1), 16'h8000); wr(mba(2, 3), 16'h1FFF); wr(mba(2, 2), 16'hFFFF);
    wr(mba(3, 1), 16'h2000); wr(mba(3, 0), 16'h0055);
    for (int m = 4; m < 7; m++) begin
      wr(mba(m, 1), 16'hA000); wr(mba(m, 3), 16'h1FFF); wr(mba(m, 2), 16'hFFFF);
    end
    wr(8'h00, 16'h005F);   // mb5 disabled
    wr(8'h01, 16'h006F);   // mb4 transmit
    rd("R2 mask high readback", mba(2, 3), 16'h1FFF);
    rd("R2 direction readback", 8'h01, 16'h006F);

    // R6 both mb0 and mb2 accept
    send(0, 0, 29'h123, 4'd8, 1, 0);
    rd("R3 std id stored", mba(0, 1), 16'h048C);
    rd("R7 dlc stored", mba(0, 4), 16'h0008);
    rd("R8 word0", mba(0, 5), 16'h7788);
    rd("R8 word1", mba(0, 6), 16'h5566);
    rd("R8 word2", mba(0, 7), 16'h3344);
    rd("R8 word3", mba(0, 8), 16'h1122);
    rd("R10 pending", 8'h02, 16'h0001);
    chk("R10 irq", 32'(rx_irq), 32'd1);

    // R4 exact miss on mb0, accept-all mb2, remote, short payload
    send(0, 1, 29'h124, 4'd3, 1, 2);
    rd("R7 id high keeps mask-enable, takes remote", mba(2, 1), 16'hC490);
    rd("R9 word0 zero", mba(2, 5), 16'h0000);
    rd("R9 word2 partial", mba(2, 7), 16'h3300);
    rd("R9 word3", mba(2, 8), 16'h1122);

    // R4 masked bits ignored, R9 zero length
    send(1, 0, 29'h1ABCDE42, 4'd0, 1, 1);
    rd("R3 ext low word", mba(1, 0), 16'hDE42);
    rd("R3 ext high word", mba(1, 1), 16'hBABC);
    rd("R9 empty payload", mba(1, 8), 16'h0000);

    // R4 unmasked bit differs, R5 skip mb4/mb5
    send(1, 0, 29'h1ABCDF42, 4'd2, 1, 6);
    rd("R5 transmit mailbox untouched", mba(4, 0), 16'h0000);
    rd("R5 disabled mailbox untouched", mba(5, 0), 16'h0000);
    rd("R4 unmasked mismatch keeps mb1", mba(1, 0), 16'hDE42);

    // R6 ext exact mb3 beats mb6
    send(1, 0, 29'h0000055, 4'd1, 1, 3);
    rd("R10 pending set", 8'h02, 16'h004F);

    // R11 overwrite pending mailbox
    send(0, 0, 29'h123, 4'd8, 1, 0);
    rd("R11 lost", 8'h03, 16'h0001);
    wr(8'h03, 16'h0000);
    rd("R11 zero write keeps lost", 8'h03, 16'h0001);
    wr(8'h03, 16'h0001);
    rd("R11 lost cleared", 8'h03, 16'h0000);
    wr(8'h02, 16'h0001);
    rd("R10 partial clear", 8'h02, 16'h004E);
    chk("R10 irq still up", 32'(rx_irq), 32'd1);
    wr(8'h02, 16'h00FF);
    chk("R10 irq cleared", 32'(rx_irq), 32'd0);

    // R4/R12 IDE mismatch drops frame
    wr(8'h00, 16'h0008);
    send(0, 0, 29'h055, 4'd4, 0, 0);
    rd("R12 dropped frame leaves pending", 8'h02, 16'h0000);
    rd("R12 dropped frame leaves dlc", mba(3, 4), 16'h0001);
    chk("R12 dropped frame irq", 32'(rx_irq), 32'd0);

    repeat (3) @(negedge clk);
    chk("R12 all results seen", 32'(exp_q.size()), 32'd0);
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule